// File: doc/BRIEF.md
# Receive Buffer with Power-of-Two Threshold Event

This block holds the words that a serial shift engine has received until a bus reader collects them. Each arriving word is stored in order of arrival. A read strobe on the receive window removes the oldest word, and the window presents that word zero-extended to 32 bits. A word-size select sets what each word is. With the select low a word is one byte and the buffer holds 32 of them. With the select high a word is 16 bits and the buffer holds 16 of them. Either way the total storage is 32 bytes.

Software sees the occupancy as a byte count, so each 16-bit word adds two to it. Writing zero to that count register empties the buffer. A 3-bit exponent sets a threshold of two to that power in words. While a separate enable is high, the block emits a single-cycle event when the stored word count comes to meet the threshold. A word that arrives while the buffer is full is discarded and raises a single-cycle overflow event. The interrupt register map lies outside this block. It consumes the two event pulses.

Top module: `rx_trigger_fifo`

## Requirements
- R1: After reset the byte level reads 0, the read window shows 0, and neither event pulse is high.
- R2: Accepted words come out in arrival order. The read window shows the oldest word zero-extended to 32 bits, and a read strobe removes it at the clock edge. In byte mode only bits 7:0 of the pushed word are kept, and in 16-bit mode (word-size select = 1) bits 15:0 are kept.
- R3: The level output equals the stored word count in byte mode and twice the stored word count in 16-bit mode.
- R4: Capacity is 32 words in byte mode and 16 words in 16-bit mode. A push into a full buffer is discarded, even in a cycle where a read strobe also frees a word. It leaves the contents unchanged except for that read, and the overflow pulse is high for the one cycle after that clock edge.
- R5: A level-register write with data 0 empties the buffer at the clock edge and takes precedence over a push or read in the same cycle. A level-register write with nonzero data has no effect.
- R6: A read strobe on an empty buffer leaves the level unchanged, and the read window shows 0 while the buffer is empty.
- R7: The threshold is 2^n words for exponent n in 0..7. Exponents whose threshold exceeds the capacity (6 and 7 in byte mode, 5 to 7 in 16-bit mode) never produce a trigger pulse.
- R8: With the enable high, the trigger pulse is high for exactly one cycle. That cycle follows the clock edge at which the word count goes from below the threshold to at or above it. The pulse can fire again only after the count has dropped back below the threshold.
- R9: With the enable low no trigger pulse is produced. Raising the enable while the count is already at or above the threshold produces the pulse in the cycle in which the enable first reads high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wide_i | input | 1 | Word size: 0 = 8-bit words, 1 = 16-bit words |
| push_i | input | 1 | A received word is offered this cycle |
| push_data_i | input | 16 | The received word |
| pop_i | input | 1 | Read strobe on the receive window |
| pop_data_o | output | 32 | Oldest word, zero-extended; 0 when empty |
| lvl_wr_i | input | 1 | Write strobe to the level register |
| lvl_wr_data_i | input | 6 | Data of the level write (0 flushes) |
| level_o | output | 6 | Occupancy in bytes |
| trig_en_i | input | 1 | Threshold event enable |
| trig_exp_i | input | 3 | Threshold exponent n (threshold 2^n words) |
| trig_pulse_o | output | 1 | Single-cycle threshold event |
| ovf_pulse_o | output | 1 | Single-cycle overflow event |

## Verification
The bench builds the block with its default parameters: 32 bytes of storage, 16-bit maximum word width and a 3-bit exponent. With these values both capacity limits can be reached within a few dozen pushes: 32 bytes in byte mode and 16 words in 16-bit mode. Overflows with and without a concurrent read are therefore exercised, as are the exponents whose thresholds lie beyond capacity. A queue-based model predicts the level, the window contents and both pulses after every clock edge. The model is also used across the switch between word sizes.

// File: rtl/rxq_pkg.sv
package rxq_pkg;

  // Size of one stored word, chosen by the word-size select input.
  typedef enum logic {
    WSZ_BYTE = 1'b0,
    WSZ_HALF = 1'b1
  } word_size_e;

endpackage

// File: rtl/rxq_rst_sync.sv
// Reset conditioner: asserts asynchronously, releases on a clock edge.
module rxq_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q <= '0;
    end else begin
      stage_q <= {stage_q[0], 1'b1};
    end
  end

  assign rst_sync_n = stage_q[1];

endmodule

// File: rtl/rxq_store.sv
// Circular word storage with independent write and read pointers.
module rxq_store #(
  parameter int unsigned DEPTH  = 32,
  parameter int unsigned WORD_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [WORD_W-1:0] wr_data,
  input  logic              rd_en,
  input  logic              flush,
  output logic [WORD_W-1:0] head_o
);

  localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

  logic [WORD_W-1:0] mem_q [DEPTH];
  logic [PTR_W-1:0]  wr_ptr_q, wr_ptr_d;
  logic [PTR_W-1:0]  rd_ptr_q, rd_ptr_d;

  // Next-state for the pointers; wrap is explicit so DEPTH need not be 2^k.
  always_comb begin
    wr_ptr_d = wr_ptr_q;
    rd_ptr_d = rd_ptr_q;
    if (flush) begin
      wr_ptr_d = '0;
      rd_ptr_d = '0;
    end else begin
      if (wr_en) begin
        wr_ptr_d = (wr_ptr_q == LAST) ? '0 : wr_ptr_q + 1'b1;
      end
      if (rd_en) begin
        rd_ptr_d = (rd_ptr_q == LAST) ? '0 : rd_ptr_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
    end else begin
      wr_ptr_q <= wr_ptr_d;
      rd_ptr_q <= rd_ptr_d;
    end
  end

  // Data array carries no reset; an empty buffer is masked at the top.
  always_ff @(posedge clk) begin
    if (wr_en) begin
      mem_q[wr_ptr_q] <= wr_data;
    end
  end

  assign head_o = mem_q[rd_ptr_q];

  // R5: after a flush both pointers meet at the same slot.
  p_ptr_flush_r5: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (wr_ptr_q == rd_ptr_q));

endmodule

// File: rtl/rxq_occupancy.sv
// Stored-word counter.
module rxq_occupancy #(
  parameter int unsigned DEPTH = 32,
  localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic             rd_en,
  input  logic             flush,
  output logic [CNT_W-1:0] count_o
);

  logic [CNT_W-1:0] count_q, count_d;

  always_comb begin
    count_d = count_q;
    if (flush) begin
      count_d = '0;
    end else begin
      unique case ({wr_en, rd_en})
        2'b10:   count_d = count_q + 1'b1;
        2'b01:   count_d = count_q - 1'b1;
        default: count_d = count_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count_q <= '0;
    end else begin
      count_q <= count_d;
    end
  end

  assign count_o = count_q;

  // R4: occupancy never exceeds the storage depth.
  p_count_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
    count_q <= CNT_W'(DEPTH));

  // R5: a flush leaves the buffer empty on the next cycle.
  p_flush_empty_r5: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (count_q == '0));

endmodule

// File: rtl/rxq_trigger.sv
// Threshold detector: pulse on entry into count >= 2^exp while enabled.
module rxq_trigger #(
  parameter int unsigned CNT_W = 6,
  parameter int unsigned EXP_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] count_i,
  input  logic             en_i,
  input  logic [EXP_W-1:0] exp_i,
  output logic             pulse_o
);

  localparam int unsigned THR_W = 1 << EXP_W;
  localparam int unsigned CMP_W = (THR_W > CNT_W) ? THR_W : CNT_W;

  logic [CMP_W-1:0] threshold;
  logic             at_thr;
  logic             at_thr_q;

  always_comb begin
    threshold = CMP_W'(1) << exp_i;
    at_thr    = en_i && (CMP_W'(count_i) >= threshold);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      at_thr_q <= 1'b0;
    end else begin
      at_thr_q <= at_thr;
    end
  end

  assign pulse_o = at_thr & ~at_thr_q;

  // R8: the event never lasts two cycles.
  p_single_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    pulse_o |=> !pulse_o);

  // R7: a threshold of at least one word cannot be met by an empty buffer.
  p_nonempty_r7: assert property (@(posedge clk) disable iff (!rst_n)
    pulse_o |-> (count_i != '0));

endmodule

// File: rtl/rx_trigger_fifo.sv
// Receive buffer with byte-level reporting, flush-on-zero and threshold event.
module rx_trigger_fifo
  import rxq_pkg::*;
#(
  parameter int unsigned BUF_BYTES = 32,
  parameter int unsigned WORD_W    = 16,
  parameter int unsigned RD_W      = 32,
  parameter int unsigned EXP_W     = 3,
  localparam int unsigned LVL_W    = $clog2(BUF_BYTES + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wide_i,
  input  logic              push_i,
  input  logic [WORD_W-1:0] push_data_i,
  input  logic              pop_i,
  output logic [RD_W-1:0]   pop_data_o,
  input  logic              lvl_wr_i,
  input  logic [LVL_W-1:0]  lvl_wr_data_i,
  output logic [LVL_W-1:0]  level_o,
  input  logic              trig_en_i,
  input  logic [EXP_W-1:0]  trig_exp_i,
  output logic              trig_pulse_o,
  output logic              ovf_pulse_o
);

  localparam int unsigned DEPTH  = BUF_BYTES;
  localparam int unsigned CNT_W  = $clog2(DEPTH + 1);
  localparam int unsigned HALF_W = WORD_W / 2;

  logic              rst_int_n;
  word_size_e        wsz;
  logic [CNT_W-1:0]  count;
  logic [CNT_W-1:0]  cap_words;
  logic              full, empty, flush;
  logic              wr_en, rd_en;
  logic [WORD_W-1:0] wr_word, head, head_sized;
  logic              ovf_d, ovf_q;

  rxq_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_int_n)
  );

  assign wsz = word_size_e'(wide_i);

  // Occupancy limit and accept/reject decisions, all from registered count.
  always_comb begin
    cap_words = (wsz == WSZ_HALF) ? CNT_W'(DEPTH / 2) : CNT_W'(DEPTH);
    full      = (count >= cap_words);
    empty     = (count == '0);
    flush     = lvl_wr_i && (lvl_wr_data_i == '0);
    wr_en     = push_i && !full && !flush;
    rd_en     = pop_i && !empty && !flush;
    ovf_d     = push_i && full && !flush;
  end

  // Narrow words keep only their low byte.
  always_comb begin
    if (wsz == WSZ_HALF) begin
      wr_word    = push_data_i;
      head_sized = head;
    end else begin
      wr_word    = {{(WORD_W - HALF_W){1'b0}}, push_data_i[HALF_W-1:0]};
      head_sized = {{(WORD_W - HALF_W){1'b0}}, head[HALF_W-1:0]};
    end
  end

  rxq_store #(
    .DEPTH  (DEPTH),
    .WORD_W (WORD_W)
  ) u_store (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .wr_en   (wr_en),
    .wr_data (wr_word),
    .rd_en   (rd_en),
    .flush   (flush),
    .head_o  (head)
  );

  rxq_occupancy #(
    .DEPTH (DEPTH)
  ) u_occ (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .wr_en   (wr_en),
    .rd_en   (rd_en),
    .flush   (flush),
    .count_o (count)
  );

  rxq_trigger #(
    .CNT_W (CNT_W),
    .EXP_W (EXP_W)
  ) u_trig (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .count_i (count),
    .en_i    (trig_en_i),
    .exp_i   (trig_exp_i),
    .pulse_o (trig_pulse_o)
  );

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      ovf_q <= 1'b0;
    end else begin
      ovf_q <= ovf_d;
    end
  end

  assign ovf_pulse_o = ovf_q;
  assign pop_data_o  = empty ? '0 : RD_W'(head_sized);
  assign level_o     = (wsz == WSZ_HALF) ? (LVL_W'(count) << 1) : LVL_W'(count);

  // R4: an overflow event follows a push offered while full.
  p_no_overflow_r4: assert property (@(posedge clk) disable iff (!rst_int_n)
    ovf_pulse_o |-> $past(push_i && full));

  // R3: the reported byte level stays within the storage size.
  p_level_cap_r3: assert property (@(posedge clk) disable iff (!rst_int_n)
    level_o <= LVL_W'(BUF_BYTES));

  // R6: a read of an empty buffer with no push leaves it empty.
  p_empty_read_r6: assert property (@(posedge clk) disable iff (!rst_int_n)
    (pop_i && empty && !push_i) |=> (level_o == '0));

endmodule

// File: tb/test_rx_trigger_fifo.sv
`timescale 1ns/1ps
module test_rx_trigger_fifo;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        wide_i;
  logic        push_i;
  logic [15:0] push_data_i;
  logic        pop_i;
  logic [31:0] pop_data_o;
  logic        lvl_wr_i;
  logic [5:0]  lvl_wr_data_i;
  logic [5:0]  level_o;
  logic        trig_en_i;
  logic [2:0]  trig_exp_i;
  logic        trig_pulse_o;
  logic        ovf_pulse_o;

  int n_chk = 0;
  int n_bad = 0;
  int trig_seen = 0;
  bit done = 0;
  int q[$];

  always #2 clk = ~clk;

  rx_trigger_fifo i_rx_trigger_fifo (
    .clk           (clk),
    .rst_n         (rst_n),
    .wide_i        (wide_i),
    .push_i        (push_i),
    .push_data_i   (push_data_i),
    .pop_i         (pop_i),
    .pop_data_o    (pop_data_o),
    .lvl_wr_i      (lvl_wr_i),
    .lvl_wr_data_i (lvl_wr_data_i),
    .level_o       (level_o),
    .trig_en_i     (trig_en_i),
    .trig_exp_i    (trig_exp_i),
    .trig_pulse_o  (trig_pulse_o),
    .ovf_pulse_o   (ovf_pulse_o)
  );

  function automatic int level_model();
    return q.size() * (wide_i ? 2 : 1);
  endfunction

  function automatic bit at_model(int sz);
    return trig_en_i && (sz >= (1 << int'(trig_exp_i)));
  endfunction

  task automatic check(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // One clock: drive inputs, advance the model at the edge, compare at negedge.
  task automatic cycle(bit ps, int pd, bit pp, bit lw, int lwd);
    int  old;
    int  cap;
    bit  a0;
    bit  ovf;
    bit  trg;
    push_i        = ps;
    push_data_i   = 16'(pd);
    pop_i         = pp;
    lvl_wr_i      = lw;
    lvl_wr_data_i = 6'(lwd);
    @(posedge clk);
    old = q.size();
    a0  = at_model(old);
    cap = wide_i ? 16 : 32;
    ovf = 0;
    if (lw && lwd == 0) begin
      q.delete();
    end else begin
      if (pp && old > 0) void'(q.pop_front());
      if (ps) begin
        if (old >= cap) ovf = 1;
        else q.push_back(wide_i ? (pd & 'hFFFF) : (pd & 'hFF));
      end
    end
    trg = at_model(q.size()) && !a0;
    @(negedge clk);
    check("R3 byte level", int'(level_o), level_model());
    check("R2 read window", int'(pop_data_o), (q.size() > 0) ? q[0] : 0);
    check("R4 overflow pulse", int'(ovf_pulse_o), int'(ovf));
    check("R8 trigger pulse", int'(trig_pulse_o), int'(trg));
    if (trig_pulse_o) trig_seen++;
    push_i   = 1'b0;
    pop_i    = 1'b0;
    lvl_wr_i = 1'b0;
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=timeout expected=completion");
      summary();
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; wide_i = 1'b0; push_i = 1'b0; push_data_i = '0;
    pop_i = 1'b0; lvl_wr_i = 1'b0; lvl_wr_data_i = '0;
    trig_en_i = 1'b0; trig_exp_i = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 level after reset", int'(level_o), 0);
    check("R1 window after reset", int'(pop_data_o), 0);
    check("R1 trigger after reset", int'(trig_pulse_o), 0);
    check("R1 overflow after reset", int'(ovf_pulse_o), 0);

    // Byte mode, threshold 8 words; upper bits of pushed data must be dropped (R2)
    trig_en_i = 1'b1; trig_exp_i = 3'd3;
    for (int i = 0; i < 10; i++) cycle(1, 'h3A0 + i, 0, 0, 0);
    for (int i = 0; i < 4; i++) cycle(0, 0, 1, 0, 0);
    for (int i = 0; i < 3; i++) cycle(1, 'h10 + i, 1, 0, 0);
    for (int i = 0; i < 2; i++) cycle(1, 'h20 + i, 0, 0, 0);

    // Fill to capacity with threshold 32, then overflow (R4)
    trig_exp_i = 3'd5;
    for (int i = 0; i < 26; i++) cycle(1, 'h40 + i, 0, 0, 0);
    check("R4 byte capacity", int'(level_o), 32);
    cycle(1, 'hEE, 0, 0, 0);
    cycle(1, 'hEF, 1, 0, 0);
    check("R4 push dropped with concurrent read", int'(level_o), 31);

    // R5 nonzero level write is ignored, zero write flushes over push and read
    cycle(0, 0, 0, 1, 5);
    check("R5 nonzero level write ignored", int'(level_o), 31);
    cycle(1, 'h55, 1, 1, 0);
    check("R5 flush empties buffer", int'(level_o), 0);

    // R6 reads of an empty buffer
    for (int i = 0; i < 3; i++) cycle(0, 0, 1, 0, 0);
    check("R6 empty read level", int'(level_o), 0);
    check("R6 empty read window", int'(pop_data_o), 0);

    // R7 unreachable thresholds in byte mode
    trig_seen = 0;
    trig_exp_i = 3'd6;
    for (int i = 0; i < 33; i++) cycle(1, i, 0, 0, 0);
    trig_exp_i = 3'd7;
    cycle(0, 0, 1, 0, 0);
    cycle(1, 1, 0, 0, 0);
    check("R7 no pulse beyond capacity", trig_seen, 0);
    cycle(0, 0, 0, 1, 0);

    // R9 enable low, then raised while above threshold
    trig_seen = 0;
    trig_en_i = 1'b0; trig_exp_i = 3'd2;
    for (int i = 0; i < 6; i++) cycle(1, 'h70 + i, 0, 0, 0);
    check("R9 no pulse while disabled", trig_seen, 0);
    trig_en_i = 1'b1;
    #1;
    check("R9 pulse on enable above threshold", int'(trig_pulse_o), 1);
    @(negedge clk);
    check("R9 pulse ends after one edge", int'(trig_pulse_o), 0);
    cycle(0, 0, 0, 1, 0);

    // 16-bit mode: threshold 16 words, byte level doubles, capacity 16 words
    wide_i = 1'b1; trig_exp_i = 3'd4;
    for (int i = 0; i < 18; i++) cycle(1, 'hBE00 + i * 'h101, 0, 0, 0);
    check("R3 wide level in bytes", int'(level_o), 32);
    check("R2 wide word kept whole", int'(pop_data_o), 'hBE00);
    for (int i = 0; i < 3; i++) cycle(0, 0, 1, 0, 0);
    cycle(1, 'hCAFE, 1, 0, 0);
    cycle(1, 'hF00D, 0, 0, 0);
    for (int i = 0; i < 16; i++) cycle(0, 0, 1, 0, 0);
    check("R6 wide empty window", int'(pop_data_o), 0);
    trig_seen = 0;
    trig_exp_i = 3'd5;
    for (int i = 0; i < 17; i++) cycle(1, i, 0, 0, 0);
    check("R7 wide threshold beyond capacity", trig_seen, 0);

    done = 1;
    summary();
    $finish;
  end

endmodule